// File: doc/BRIEF.md
# Wide register write collector

This block turns a 32-bit host write port into atomic updates of internal registers that are wider than one bus beat. Dword writes aimed at a 128-bit control register or a 64-bit memory word are gathered in a single collector. Once every dword of the target has arrived, the whole value is presented in one cycle on a commit port, together with the target's aligned address and a class code. Plain 32-bit registers bypass the collector and are committed directly.

Descriptor-pointer registers are 128-bit and write-only, and they follow looser rules. A write to their top dword always commits, and any low dword the collector has not gathered for that register is filled with zero. A write to one of their lower dwords is dropped while the collector is busy with some other register. Per-queue registers repeat in pages of 0x2000 bytes. Every page is decoded the same way by the in-page offset: 0x000–0x3FF are 128-bit control registers, 0x400–0x7FF are plain registers, 0x800–0xBFF are descriptor pointers and 0xC00–0x1FFF are 64-bit memory words. Reads are passed through from the register side, except reads of descriptor pointers, which return zero.

Top module: `wide_write_collector`

## Requirements
- R1: A 128-bit control register commits with class code 1 only after all four of its dwords have been written, in any order. Dword n (byte offset 4n) lands in bits 32n+31:32n. The commit address is the 16-byte aligned base.
- R2: A write to a 128-bit control register with a different base, made while the collector holds partial data, discards the old partial data and restarts collection with the new dword.
- R3: A 64-bit memory word commits with class code 2 once both of its dwords are present, in either order. The commit address is 8-byte aligned and bits 127:64 of the commit data are zero.
- R4: A write to the top dword (offset 0xC) of a descriptor pointer always commits with class code 3. Low dwords already gathered for the same register are kept and all others are zero.
- R5: A write to a lower dword of a descriptor pointer is dropped, leaving the collector unchanged, while the collector holds data for another register.
- R6: A plain register write commits with class code 0, the full byte address and the dword in bits 31:0. It leaves the collector contents and its valid set untouched.
- R7: A read raises rd_valid for one cycle in the next cycle. rd_data is zero for a descriptor-pointer address and rd_return otherwise. A read does not disturb the collector.
- R8: The address class is decoded from the low 13 address bits. The bits above them select the page and are carried unchanged into the commit address.
- R9: commit_valid is a one-cycle strobe in the cycle after the completing write. Reset clears the outputs and the collector's valid set, and every commit clears the valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host dword write |
| rd_en | input | 1 | Host dword read |
| addr | input | ADDR_W | Host byte address |
| wdata | input | DW | Host write data |
| rd_return | input | DW | Dword returned by the register side for a read |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_kind | output | 2 | Class: 0 plain, 1 control, 2 memory word, 3 descriptor |
| commit_addr | output | ADDR_W | Aligned target address |
| commit_data | output | 4*DW | Full-width committed value |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |

## Verification
The assertions assume that each host cycle carries a single access, so a read and a write never share a cycle. They also assume that addresses are dword-aligned. The stimulus issues one access per cycle and uses only aligned addresses. It interleaves classes, pages and dword orders so that the collector's ownership rules, rather than the plain arrival order, decide every commit.

// File: rtl/wide_write_collector.sv
module wide_write_collector #(
  parameter int ADDR_W      = 20,
  parameter int PAGE_SHIFT  = 13,
  parameter int DW          = 32,
  parameter int CSR_LIMIT   = 'h400,
  parameter int PLAIN_LIMIT = 'h800,
  parameter int DESC_LIMIT  = 'hC00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DW-1:0]       wdata,
  input  logic [DW-1:0]       rd_return,
  output logic                commit_valid,
  output logic [1:0]          commit_kind,
  output logic [ADDR_W-1:0]   commit_addr,
  output logic [4*DW-1:0]     commit_data,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data
);
  localparam int WIDE = 4 * DW;
  localparam logic [1:0] K_PLAIN = 2'd0, K_CSR = 2'd1, K_SRAM = 2'd2, K_DESC = 2'd3;
  localparam logic [PAGE_SHIFT-1:0] CSR_LIM   = PAGE_SHIFT'(CSR_LIMIT);
  localparam logic [PAGE_SHIFT-1:0] PLAIN_LIM = PAGE_SHIFT'(PLAIN_LIMIT);
  localparam logic [PAGE_SHIFT-1:0] DESC_LIM  = PAGE_SHIFT'(DESC_LIMIT);

  wire [PAGE_SHIFT-1:0] offs = addr[PAGE_SHIFT-1:0];
  logic [1:0] cls;
  always_comb begin
    if (offs < CSR_LIM)        cls = K_CSR;
    else if (offs < PLAIN_LIM) cls = K_PLAIN;
    else if (offs < DESC_LIM)  cls = K_DESC;
    else                       cls = K_SRAM;
  end

  wire [1:0] slot = (cls == K_SRAM) ? {1'b0, addr[2]} : addr[3:2];
  wire [3:0] slot_bit = 4'b0001 << slot;
  wire [ADDR_W-1:0] base = (cls == K_SRAM) ? {addr[ADDR_W-1:3], 3'b000} : {addr[ADDR_W-1:4], 4'b0000};
  wire [3:0] full = (cls == K_SRAM) ? 4'b0011 : 4'b1111;

  logic [ADDR_W-1:0] col_base;
  logic [1:0]        col_kind;
  logic [3:0]        col_mask;
  logic [WIDE-1:0]   col_data;

  wire owned = (col_mask == 4'b0) || (col_base == base && col_kind == cls);
  wire [3:0] merged_mask = (owned ? col_mask : 4'b0) | slot_bit;
  logic [WIDE-1:0] merged_data;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_slot
      assign merged_data[g*DW +: DW] = (slot == 2'(g)) ? wdata :
                                       (owned && col_mask[g]) ? col_data[g*DW +: DW] : '0;
    end
  endgenerate

  wire wr_plain     = wr_en && cls == K_PLAIN;
  wire wr_desc_top  = wr_en && cls == K_DESC && slot == 2'd3;
  wire wr_desc_drop = wr_en && cls == K_DESC && slot != 2'd3 && !owned;
  wire wr_collect   = wr_en && cls != K_PLAIN && !wr_desc_top && !wr_desc_drop;
  wire wide_done    = wr_collect && ((merged_mask & full) == full);
  wire do_commit    = wr_plain || wr_desc_top || wide_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_base <= '0;
      col_kind <= K_PLAIN;
      col_mask <= '0;
      col_data <= '0;
    end else if (wr_desc_top || wide_done) begin
      col_mask <= '0;
    end else if (wr_collect) begin
      col_base <= base;
      col_kind <= cls;
      col_mask <= merged_mask;
      col_data <= merged_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
      commit_kind  <= K_PLAIN;
      commit_addr  <= '0;
      commit_data  <= '0;
    end else begin
      commit_valid <= do_commit;
      if (do_commit) begin
        commit_kind <= cls;
        commit_addr <= wr_plain ? addr : base;
        commit_data <= wr_plain ? {{(WIDE-DW){1'b0}}, wdata} : merged_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= (cls == K_DESC) ? '0 : rd_return;
    end
  end

  a_r6_plain_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && offs >= CSR_LIM && offs < PLAIN_LIM) |=>
      (commit_valid && commit_kind == K_PLAIN && commit_data[DW-1:0] == $past(wdata)));
  a_r6_plain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && offs >= CSR_LIM && offs < PLAIN_LIM) |=> ($stable(col_mask) && $stable(col_data)));
  a_r4_desc_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && offs >= PLAIN_LIM && offs < DESC_LIM && addr[3:2] == 2'd3) |=>
      (commit_valid && commit_kind == K_DESC && commit_data[WIDE-1:WIDE-DW] == $past(wdata) && col_mask == 4'b0));
  a_r5_desc_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && offs >= PLAIN_LIM && offs < DESC_LIM && addr[3:2] != 2'd3 && col_mask != 4'b0 &&
     (col_kind != K_DESC || col_base != {addr[ADDR_W-1:4], 4'b0000})) |=>
      ($stable(col_mask) && $stable(col_data) && !commit_valid));
  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> (rd_valid && $stable(col_mask) && $stable(col_data)));
  a_r7_desc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && offs >= PLAIN_LIM && offs < DESC_LIM) |=> (rd_data == '0));
  a_r9_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(wr_en));
  a_r3_sram_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_kind == K_SRAM) |-> (commit_data[WIDE-1:2*DW] == '0));
  a_r3_sram_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (col_kind == K_SRAM) |-> (col_mask[3:2] == 2'b00));
endmodule

// File: tb/wide_write_collector_test.sv
module wide_write_collector_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_return = 32'hCAFE_F00D;
  logic commit_valid, rd_valid;
  logic [1:0] commit_kind;
  logic [19:0] commit_addr;
  logic [127:0] commit_data;
  logic [31:0] rd_data;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  wide_write_collector uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_return(rd_return), .commit_valid(commit_valid),
    .commit_kind(commit_kind), .commit_addr(commit_addr), .commit_data(commit_data),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // {op, req, addr, wdata, exp_valid, exp_kind, exp_addr, exp_data}; op 1 write, 2 read
  localparam int NV = 43;
  localparam logic [208:0] VEC [NV] = '{
    {2'd1,4'd1,20'h00010,32'hA0,1'b0,2'd0,20'h0,128'h0},                           // R1
    {2'd1,4'd1,20'h00014,32'hA1,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd6,20'h00404,32'hB0,1'b1,2'd0,20'h00404,{96'h0,32'hB0}},                // R6
    {2'd1,4'd1,20'h00018,32'hA2,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd1,20'h0001C,32'hA3,1'b1,2'd1,20'h00010,{32'hA3,32'hA2,32'hA1,32'hA0}},
    {2'd1,4'd1,20'h0002C,32'hE3,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd1,20'h00020,32'hE0,1'b0,2'd0,20'h0,128'h0},
    {2'd2,4'd7,20'h00064,32'h0,1'b1,2'd0,20'h0,{96'h0,32'hCAFEF00D}},               // R7
    {2'd1,4'd1,20'h00028,32'hE2,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd1,20'h00024,32'hE1,1'b1,2'd1,20'h00020,{32'hE3,32'hE2,32'hE1,32'hE0}},
    {2'd1,4'd2,20'h00030,32'hF0,1'b0,2'd0,20'h0,128'h0},                           // R2
    {2'd1,4'd2,20'h00040,32'h60,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd2,20'h00044,32'h61,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd2,20'h00048,32'h62,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd2,20'h0004C,32'h63,1'b1,2'd1,20'h00040,{32'h63,32'h62,32'h61,32'h60}},
    {2'd1,4'd3,20'h00C08,32'h50,1'b0,2'd0,20'h0,128'h0},                           // R3
    {2'd1,4'd3,20'h00C0C,32'h51,1'b1,2'd2,20'h00C08,{64'h0,32'h51,32'h50}},
    {2'd1,4'd3,20'h00C14,32'h71,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd3,20'h00C10,32'h70,1'b1,2'd2,20'h00C10,{64'h0,32'h71,32'h70}},
    {2'd1,4'd4,20'h0083C,32'h83,1'b1,2'd3,20'h00830,{32'h83,96'h0}},               // R4
    {2'd1,4'd4,20'h00834,32'h91,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd4,20'h0083C,32'h93,1'b1,2'd3,20'h00830,{32'h93,32'h0,32'h91,32'h0}},
    {2'd1,4'd4,20'h00830,32'hC0,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd4,20'h00834,32'hC1,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd4,20'h00838,32'hC2,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd4,20'h0083C,32'hC3,1'b1,2'd3,20'h00830,{32'hC3,32'hC2,32'hC1,32'hC0}},
    {2'd1,4'd5,20'h00010,32'hD0,1'b0,2'd0,20'h0,128'h0},                           // R5
    {2'd1,4'd5,20'h00834,32'h11,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd5,20'h00014,32'hD1,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd5,20'h00018,32'hD2,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd5,20'h0001C,32'hD3,1'b1,2'd1,20'h00010,{32'hD3,32'hD2,32'hD1,32'hD0}},
    {2'd1,4'd5,20'h0083C,32'h33,1'b1,2'd3,20'h00830,{32'h33,96'h0}},
    {2'd1,4'd8,20'h02834,32'h21,1'b0,2'd0,20'h0,128'h0},                           // R8
    {2'd1,4'd8,20'h0283C,32'h23,1'b1,2'd3,20'h02830,{32'h23,32'h0,32'h21,32'h0}},
    {2'd1,4'd8,20'h00834,32'h41,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd8,20'h0283C,32'h43,1'b1,2'd3,20'h02830,{32'h43,96'h0}},
    {2'd1,4'd8,20'h06400,32'h77,1'b1,2'd0,20'h06400,{96'h0,32'h77}},
    {2'd1,4'd8,20'h04010,32'h100,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd8,20'h04014,32'h101,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd8,20'h04018,32'h102,1'b0,2'd0,20'h0,128'h0},
    {2'd1,4'd8,20'h0401C,32'h103,1'b1,2'd1,20'h04010,{32'h103,32'h102,32'h101,32'h100}},
    {2'd2,4'd7,20'h00830,32'h0,1'b1,2'd0,20'h0,128'h0},                            // R7
    {2'd2,4'd7,20'h00404,32'h0,1'b1,2'd0,20'h0,{96'h0,32'hCAFEF00D}}
  };

  task automatic check(input bit ok, input int req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [19:0] a, input logic [31:0] d);
    wr_en = (op == 2'd1);
    rd_en = (op == 2'd2);
    addr  = a;
    wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!commit_valid && !rd_valid && commit_data == '0, 9, {126'h0, commit_valid, rd_valid}, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [208:0] v;
      v = VEC[i];
      drive(v[208:207], v[202:183], v[182:151]);
      @(negedge clk);
      if (v[208:207] == 2'd2)
        check(rd_valid && !commit_valid && rd_data == v[31:0], int'(v[206:203]),
              {95'h0, rd_valid, rd_data}, {95'h0, 1'b1, v[31:0]});
      else if (v[150])
        check(commit_valid && !rd_valid && commit_kind == v[149:148] && commit_addr == v[147:128]
              && commit_data == v[127:0], int'(v[206:203]), commit_data, v[127:0]);
      else
        check(!commit_valid && !rd_valid, int'(v[206:203]), {126'h0, commit_valid, rd_valid}, 128'h0);
    end
    drive(2'd0, '0, '0);
    @(negedge clk);
    // R9: strobe lasts one cycle
    check(!commit_valid, 9, {127'h0, commit_valid}, 128'h0);

    // R9: reset in mid-collection clears the valid set
    drive(2'd1, 20'h00070, 32'h1);  @(negedge clk);
    drive(2'd1, 20'h00074, 32'h2);  @(negedge clk);
    drive(2'd0, '0, '0);
    rst_n = 1'b0; @(negedge clk);
    check(!commit_valid && !rd_valid, 9, {126'h0, commit_valid, rd_valid}, 128'h0);
    rst_n = 1'b1; @(negedge clk);
    drive(2'd1, 20'h00078, 32'h3);  @(negedge clk);
    drive(2'd1, 20'h0007C, 32'h4);  @(negedge clk);
    drive(2'd1, 20'h00074, 32'h5);  @(negedge clk);
    check(!commit_valid, 9, {127'h0, commit_valid}, 128'h0);
    drive(2'd1, 20'h00070, 32'h6);  @(negedge clk);
    check(commit_valid && commit_addr == 20'h00070 && commit_data == {32'h4, 32'h3, 32'h5, 32'h6},
          9, commit_data, {32'h4, 32'h3, 32'h5, 32'h6});
    drive(2'd0, '0, '0);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule